// File: doc/BRIEF.md
# Fractional-Increment Nanosecond Time Counter

This block keeps the precision time of a network port as a free-running 64-bit count of nanoseconds. A 32-bit fraction register extends it. While the run bit is set, every clock cycle adds a 64-bit fixed-point increment to the combined 96-bit value. The increment holds whole nanoseconds in its upper 32 bits and a fraction of a nanosecond in its lower 32 bits, so a clock period that is not a whole number of nanoseconds still tracks real time. The 64-bit range is wide enough that wrap-around never matters in practice.

Software reaches the block through a simple 32-bit register bus. Time and increment are split into low and high words. A read of the low time word also captures the upper half, so the high-word read that follows belongs to the same instant. Writes to the low words are held in staging registers, and nothing takes effect until the matching high word is written. The link-speed input supplies a default increment whenever it changes. Software can overwrite that default afterwards to trim the clock's frequency. The running time is also presented on a parallel output for timestamp consumers.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset the time is 0, the fraction is 0, the run bit is 0 and the increment reads 0x00000001_99999999 (the fastest-link default).
- R2: While the run bit is 0 and no time commit occurs, the time output holds its value.
- R3: While the run bit is 1, each clock adds the increment to {time, fraction}, and the carry out of the 32-bit fraction enters the nanosecond count. The time wraps modulo 2^64.
- R4: A change on link_speed loads a default increment. Code 0 (fastest or no link) loads 0x0199999999 (1.6 ns), code 1 loads 0x0333333333 (3.2 ns) and code 2 loads 0x2000000000 (32 ns).
- R5: Code 3 (unsupported speed) loads an increment of zero, so the time stops advancing even with the run bit set.
- R6: A read of address 0 returns time[31:0] and captures time[63:32]. A later read of address 1 returns that captured value, not the live upper half.
- R7: A write to address 0 only stages the low word and leaves the time unchanged. A write to address 1 loads time = {data, staged low} and clears the fraction on that edge.
- R8: A time commit on the same cycle as a running tick takes priority, so that tick's increment is not added.
- R9: A write to address 2 only stages the increment low word. A write to address 3 loads increment = {data, staged low}. Addresses 2 and 3 read back the active increment.
- R10: Bit 0 of address 4 is the run bit. It is written and read back there, and the other bits read 0.
- R11: A software increment commit wins over a link-speed change in the same cycle. The software value persists until link_speed changes again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_speed | input | 2 | Link speed code that selects the default increment |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (needed for the snapshot) |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |
| time_ns | output | 64 | Current time in nanoseconds |

## Verification
The assertions check on every cycle that the time is held when the counter is stopped, that a tick never advances the time by more than the increment's whole part plus one, that a high-word commit lands the written upper half, and that a high read returns what the preceding low read captured. Only the bench scenarios show the fraction accumulating precisely over many cycles, the link-speed defaults and their priority against software, the stop at the unsupported speed, and the wrap of the time at 2^64. A cycle-accurate model in the bench tracks all of this under random bus traffic.

// File: rtl/ptp_time_counter.sv
module ptp_time_counter #(
  parameter int          AW       = 3,
  parameter logic [63:0] INC_FAST = 64'h0000_0001_9999_9999,
  parameter logic [63:0] INC_MID  = 64'h0000_0003_3333_3333,
  parameter logic [63:0] INC_SLOW = 64'h0000_0020_0000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    link_speed,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic [63:0]   time_ns
);
  localparam logic [AW-1:0] A_TLO = AW'(0), A_THI = AW'(1), A_ILO = AW'(2),
                            A_IHI = AW'(3), A_CTL = AW'(4);

  logic [63:0] tm_q, inc_q;
  logic [31:0] frac_q, tstage_q, istage_q, snap_q;
  logic        run_q;
  logic [1:0]  spd_q;
  logic [63:0] dflt_inc;
  logic [95:0] sum;
  logic        t_commit, i_commit;

  assign t_commit = bus_wr && bus_addr == A_THI;
  assign i_commit = bus_wr && bus_addr == A_IHI;
  assign sum      = {tm_q, frac_q} + {32'd0, inc_q};
  assign time_ns  = tm_q;

  always_comb begin
    case (link_speed)
      2'd1:    dflt_inc = INC_MID;
      2'd2:    dflt_inc = INC_SLOW;
      2'd3:    dflt_inc = 64'd0;
      default: dflt_inc = INC_FAST;
    endcase
  end

  always_comb begin
    case (bus_addr)
      A_TLO:   bus_rdata = tm_q[31:0];
      A_THI:   bus_rdata = snap_q;
      A_ILO:   bus_rdata = inc_q[31:0];
      A_IHI:   bus_rdata = inc_q[63:32];
      A_CTL:   bus_rdata = {31'd0, run_q};
      default: bus_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tm_q     <= '0;
      frac_q   <= '0;
      inc_q    <= INC_FAST;
      tstage_q <= '0;
      istage_q <= '0;
      snap_q   <= '0;
      run_q    <= 1'b0;
      spd_q    <= 2'd0;
    end else begin
      if (t_commit) begin
        tm_q   <= {bus_wdata, tstage_q};
        frac_q <= '0;
      end else if (run_q) begin
        {tm_q, frac_q} <= sum;
      end

      if (i_commit)                 inc_q <= {bus_wdata, istage_q};
      else if (link_speed != spd_q) inc_q <= dflt_inc;
      spd_q <= link_speed;

      if (bus_wr && bus_addr == A_TLO) tstage_q <= bus_wdata;
      if (bus_wr && bus_addr == A_ILO) istage_q <= bus_wdata;
      if (bus_wr && bus_addr == A_CTL) run_q    <= bus_wdata[0];
      if (bus_rd && bus_addr == A_TLO) snap_q   <= tm_q[63:32];
    end
  end
endmodule

module ptp_time_counter_chk #(parameter int AW = 3) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic [31:0]   bus_rdata,
  input logic [63:0]   time_ns,
  input logic [63:0]   inc_q,
  input logic          run_q
);
  logic hi_wr;
  assign hi_wr = bus_wr && bus_addr == AW'(1);

  assert_hold_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !hi_wr) |=> $stable(time_ns));

  assert_step_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !hi_wr) |=> (time_ns - $past(time_ns)) <= {32'd0, $past(inc_q[63:32])} + 64'd1);

  assert_hi_read_snap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == AW'(0)) |=> (bus_addr != AW'(1) || bus_rdata == $past(time_ns[63:32])));

  assert_time_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> time_ns[63:32] == $past(bus_wdata));

  assert_inc_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(3)) |=> inc_q[63:32] == $past(bus_wdata));
endmodule

bind ptp_time_counter ptp_time_counter_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .time_ns(time_ns), .inc_q(inc_q), .run_q(run_q));

// File: tb/ptp_time_counter_tb.sv
module ptp_time_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  link_speed = 2'd0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic [63:0] time_ns;

  int tests = 0, fails = 0;
  logic [63:0] m_t, m_inc;
  logic [31:0] m_f, m_ts, m_is, m_snap;
  logic        m_run;
  logic [1:0]  m_spd;

  ptp_time_counter dut_i (.clk(clk), .rst_n(rst_n), .link_speed(link_speed),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .time_ns(time_ns));

  always #10 clk = ~clk;

  function automatic logic [63:0] dflt(input logic [1:0] s);
    case (s)
      2'd0: return 64'h0199999999;
      2'd1: return 64'h0333333333;
      2'd2: return 64'h2000000000;
      default: return 64'd0;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_t[31:0];
      3'd1: return m_snap;
      3'd2: return m_inc[31:0];
      3'd3: return m_inc[63:32];
      3'd4: return {31'd0, m_run};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input string req, input logic wr, input logic rd,
                    input logic [2:0] a, input logic [31:0] d, input logic [1:0] spd);
    logic [95:0] s;
    @(negedge clk);
    chk({req, " time"}, time_ns, m_t);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; link_speed = spd;
    #1;
    if (rd) chk({req, " rdata"}, {32'd0, bus_rdata}, {32'd0, exp_rd(a)});
    s = {m_t, m_f} + {32'd0, m_inc};
    if (rd && a == 3'd0) m_snap = m_t[63:32];
    if (wr && a == 3'd1) begin m_t = {d, m_ts}; m_f = 32'd0; end
    else if (m_run) {m_t, m_f} = s;
    if (wr && a == 3'd3) m_inc = {d, m_is};
    else if (spd != m_spd) m_inc = dflt(spd);
    m_spd = spd;
    if (wr && a == 3'd0) m_ts = d;
    if (wr && a == 3'd2) m_is = d;
    if (wr && a == 3'd4) m_run = d[0];
    @(posedge clk);
  endtask

  task automatic idle(input string req, input int n);
    for (int i = 0; i < n; i++) op(req, 1'b0, 1'b0, 3'd0, 32'd0, link_speed);
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    m_t = 0; m_f = 0; m_inc = 64'h0199999999; m_ts = 0; m_is = 0; m_snap = 0;
    m_run = 0; m_spd = 0;
    void'($urandom(32'd1588));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    op("R1", 0, 1, 3'd2, 0, 2'd0);
    op("R1", 0, 1, 3'd3, 0, 2'd0);
    op("R1", 0, 1, 3'd4, 0, 2'd0);
    // R2 stopped counter holds
    idle("R2", 4);
    // R10 run bit, R3 accumulation with fraction carry
    op("R10", 1, 0, 3'd4, 32'hFFFF_FFFF, 2'd0);
    op("R10", 0, 1, 3'd4, 0, 2'd0);
    idle("R3", 20);
    // R4 link defaults
    op("R4", 0, 0, 3'd0, 0, 2'd1);
    op("R4", 0, 1, 3'd3, 0, 2'd1);
    idle("R4", 10);
    op("R4", 0, 0, 3'd0, 0, 2'd2);
    op("R4", 0, 1, 3'd3, 0, 2'd2);
    idle("R4", 10);
    // R5 unsupported speed stops the clock
    op("R5", 0, 0, 3'd0, 0, 2'd3);
    op("R5", 0, 1, 3'd2, 0, 2'd3);
    idle("R5", 5);
    op("R5", 0, 0, 3'd0, 0, 2'd0);
    // R7 staging then commit, R8 commit beats tick (counter running)
    op("R7", 1, 0, 3'd0, 32'hFFFF_FFF0, 2'd0);
    idle("R7", 2);
    op("R8", 1, 0, 3'd1, 32'hFFFF_FFFF, 2'd0);
    // R3 wrap at 2^64
    idle("R3", 20);
    // R6 snapshot: low read then later high read
    op("R6", 0, 1, 3'd0, 0, 2'd0);
    idle("R6", 3);
    op("R6", 0, 1, 3'd1, 0, 2'd0);
    // R9 increment staging and commit, R11 sw beats link change
    op("R9", 1, 0, 3'd2, 32'h1234_5678, 2'd0);
    op("R9", 0, 1, 3'd2, 0, 2'd0);
    op("R11", 1, 0, 3'd3, 32'h0000_0005, 2'd1);
    op("R11", 0, 1, 3'd3, 0, 2'd1);
    idle("R11", 5);
    op("R11", 0, 1, 3'd2, 0, 2'd1);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      logic [1:0]  sp;
      r = $urandom;
      sp = (r[31:28] == 4'd0) ? r[27:26] : m_spd;
      op("R3", r[0] & r[1], ~r[0], 3'(r[4:2] % 5),
         (r[4:2] % 5 == 4) ? {31'd0, ~r[5] | r[6]} : $urandom, sp);
    end
    @(negedge clk);
    chk("R3 final", time_ns, m_t);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule